// File: doc/BRIEF.md
# General-Purpose Up-Counting Timer Core

This block is the counting engine of a general-purpose timer. A counter of `W` bits runs upward while the run bit of the control word is set, advancing on cycles where the functional-clock enable `fclk_en` is high. An optional prescaler divides these enables by a power of two. When the counter passes its all-ones value it overflows. It then either reloads from the load register and keeps running, or wraps to zero and stops by clearing its own run bit.

A compare unit reports when the counter reaches the match value. A capture unit stores the counter on a chosen edge of an external pin. It can use one capture register, or two registers filled by alternate edges. A waveform output either pulses or toggles on overflow, or on overflow and match. The three events leave the block as one-cycle pulses for a separate interrupt block.

Register writes arrive as single-cycle strobes from a bus front end outside the block. The control word can be read back, because overflow can clear its run bit.

Top module: `gpt_timer_core`

## Requirements
- R1: After synchronous reset, `count_o`, `ctrl_o`, both capture outputs, all event outputs and `pwm_o` are 0.
- R2: While control bit 0 (run) is set and bit 5 is clear, `count_o` rises by one on every clock with `fclk_en` high. It holds when `fclk_en` is low or run is clear. The first increment follows the clock that latched run.
- R3: With bit 5 set, the counter advances once per 2^(p+1) enabled clocks, where p is the ratio field in bits 4:2. A control write restarts the division.
- R4: When `count_o` is all ones and a count step occurs, `evt_ovf` pulses for one cycle. If bit 1 (auto-reload) is set, the count becomes the load value and counting continues. If bit 1 is clear, the count becomes 0 and bit 0 of `ctrl_o` clears.
- R5: A `trig_wr` strobe copies the load value into the counter on the next clock, whether or not the counter runs.
- R6: `cnt_wr` sets the counter from `cnt_wdata` on the next clock. It takes priority over `trig_wr` and over a count step in the same cycle.
- R7: With bit 6 set, `evt_match` is high in exactly the cycle in which `count_o` first shows the match value. With bit 6 clear it stays low.
- R8: The edge field in bits 9:8 selects no capture (0), rising (1), falling (2) or both edges (3) of `cap_in`. On a selected edge, sampled on an `fclk_en` clock, `cap1_o` takes the count held before that clock and `evt_cap` pulses one cycle later.
- R9: With bit 13 set, the first selected edge fills `cap1_o` and raises no event. The second fills `cap2_o` and raises `evt_cap`. A control write re-arms the sequence at the first edge.
- R10: Field bits 11:10 selects the output trigger: none (0 or 3), overflow (1), or overflow and match (2). A control write loads `pwm_o` with bit 7, the default level. With trigger none, `pwm_o` keeps that level.
- R11: With bit 12 set (toggle), `pwm_o` inverts in the cycle each selected event appears. With bit 12 clear (pulse), `pwm_o` shows the inverse of bit 7 in that cycle and returns to bit 7 on the next.
- R12: `ctrl_o` reads back the control word, and `gpo_cfg_o` follows bit 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fclk_en | input | 1 | Functional-clock enable |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word data |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter write data |
| load_wr | input | 1 | Load register write strobe |
| load_wdata | input | W | Load register data |
| match_wr | input | 1 | Match register write strobe |
| match_wdata | input | W | Match register data |
| trig_wr | input | 1 | Trigger strobe that forces a reload |
| cap_in | input | 1 | Capture input pin |
| count_o | output | W | Current counter value |
| ctrl_o | output | 16 | Control word readback |
| cap1_o | output | W | First capture register |
| cap2_o | output | W | Second capture register |
| evt_match | output | 1 | Match event pulse |
| evt_ovf | output | 1 | Overflow event pulse |
| evt_cap | output | 1 | Capture event pulse |
| pwm_o | output | 1 | Waveform output |
| gpo_cfg_o | output | 1 | General-purpose pin configuration bit |

## Verification
The bench targets the wrap at all ones in both reload settings. A design that confuses them either keeps running from zero, or stops after reloading. It also checks the exact cycle of the first increment after start, and the 4-enable spacing with prescaler ratio 1, where an off-by-one in the terminal count shows up at once. Further checks cover a counter write and a trigger in the same cycle, a falling edge while only rising is selected, and the two-step dual capture, which a design that raises the event too early would fail. Both waveform modes are followed through match and overflow. A wrong toggle or pulse level appears in the first event cycle.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int CTRL_W  = 16;
  localparam int RATIO_W = 3;

  typedef enum logic [1:0] {
    TRIG_NONE      = 2'd0,
    TRIG_OVF       = 2'd1,
    TRIG_OVF_MATCH = 2'd2,
    TRIG_RSVD      = 2'd3
  } trig_sel_e;

  typedef struct packed {
    logic               rsvd;
    logic               gpo;
    logic               cap_dual;
    logic               toggle;
    trig_sel_e          trig;
    logic [1:0]         edge_sel;
    logic               def_lvl;
    logic               cmp_en;
    logic               pre_en;
    logic [RATIO_W-1:0] ratio;
    logic               reload;
    logic               run;
  } gpt_ctrl_t;
endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               en,
  input  logic               pre_en,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  localparam int DIV_W = 2 ** RATIO_W;

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] term;
  logic [RATIO_W:0] shamt;

  always_comb begin
    shamt = {1'b0, ratio} + 1'b1;
    term  = (DIV_W'(1) << shamt) - DIV_W'(1);
    tick  = en & (~pre_en | (pcnt == term));
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !pre_en) begin
      pcnt <= '0;
    end else if (en) begin
      pcnt <= (pcnt == term) ? '0 : pcnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/gpt_count.sv
module gpt_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         trig_wr,
  input  logic [W-1:0] load,
  input  logic [W-1:0] match,
  input  logic         reload,
  input  logic         cmp_en,
  output logic [W-1:0] count,
  output logic         ovf_now,
  output logic         match_now
);
  logic [W-1:0] nxt;
  logic         step;
  logic         at_top;

  always_comb begin
    step   = tick & ~cnt_wr & ~trig_wr;
    at_top = &count;
    if (cnt_wr)       nxt = cnt_wdata;
    else if (trig_wr) nxt = load;
    else if (tick)    nxt = at_top ? (reload ? load : '0) : count + W'(1);
    else              nxt = count;
    ovf_now   = step & at_top;
    match_now = step & cmp_en & (nxt == match);
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= nxt;
  end
endmodule

// File: rtl/gpt_capture.sv
module gpt_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fclk_en,
  input  logic         cap_in,
  input  logic [1:0]   edge_sel,
  input  logic         dual,
  input  logic         rearm,
  input  logic [W-1:0] count,
  output logic [W-1:0] cap1,
  output logic [W-1:0] cap2,
  output logic         evt
);
  logic prev;
  logic second;
  logic hit;

  always_comb begin
    hit = fclk_en & ((edge_sel[0] & cap_in & ~prev) |
                     (edge_sel[1] & ~cap_in & prev));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= 1'b0;
      second <= 1'b0;
      cap1   <= '0;
      cap2   <= '0;
      evt    <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (fclk_en) prev <= cap_in;
      if (hit) begin
        if (!dual) begin
          cap1 <= count;
          evt  <= 1'b1;
        end else if (!second) begin
          cap1   <= count;
          second <= 1'b1;
        end else begin
          cap2   <= count;
          second <= 1'b0;
          evt    <= 1'b1;
        end
      end
      if (rearm) second <= 1'b0;
    end
  end
endmodule

// File: rtl/gpt_pwm.sv
module gpt_pwm
  import gpt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load_def,
  input  logic      new_def,
  input  logic      def_lvl,
  input  trig_sel_e trig,
  input  logic      toggle,
  input  logic      ovf_now,
  input  logic      match_now,
  output logic      pwm
);
  logic fire;

  always_comb begin
    unique case (trig)
      TRIG_OVF:       fire = ovf_now;
      TRIG_OVF_MATCH: fire = ovf_now | match_now;
      default:        fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           pwm <= 1'b0;
    else if (load_def) pwm <= new_def;
    else if (fire)     pwm <= toggle ? ~pwm : ~def_lvl;
    else if (!toggle)  pwm <= def_lvl;
  end
endmodule

// File: rtl/gpt_timer_core.sv
module gpt_timer_core
  import gpt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fclk_en,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              cnt_wr,
  input  logic [W-1:0]      cnt_wdata,
  input  logic              load_wr,
  input  logic [W-1:0]      load_wdata,
  input  logic              match_wr,
  input  logic [W-1:0]      match_wdata,
  input  logic              trig_wr,
  input  logic              cap_in,
  output logic [W-1:0]      count_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [W-1:0]      cap1_o,
  output logic [W-1:0]      cap2_o,
  output logic              evt_match,
  output logic              evt_ovf,
  output logic              evt_cap,
  output logic              pwm_o,
  output logic              gpo_cfg_o
);
  gpt_ctrl_t    ctrl_q;
  gpt_ctrl_t    ctrl_new;
  logic [W-1:0] load_q;
  logic [W-1:0] match_q;
  logic         tick;
  logic         ovf_now;
  logic         match_now;

  assign ctrl_new = gpt_ctrl_t'(ctrl_wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      load_q    <= '0;
      match_q   <= '0;
      evt_ovf   <= 1'b0;
      evt_match <= 1'b0;
    end else begin
      if (ctrl_wr)                       ctrl_q     <= ctrl_new;
      else if (ovf_now && !ctrl_q.reload) ctrl_q.run <= 1'b0;
      if (load_wr)  load_q  <= load_wdata;
      if (match_wr) match_q <= match_wdata;
      evt_ovf   <= ovf_now;
      evt_match <= match_now;
    end
  end

  gpt_prescale #(.RATIO_W(RATIO_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr    (ctrl_wr | ~ctrl_q.run),
    .en     (fclk_en & ctrl_q.run),
    .pre_en (ctrl_q.pre_en),
    .ratio  (ctrl_q.ratio),
    .tick   (tick)
  );

  gpt_count #(.W(W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .trig_wr   (trig_wr),
    .load      (load_q),
    .match     (match_q),
    .reload    (ctrl_q.reload),
    .cmp_en    (ctrl_q.cmp_en),
    .count     (count_o),
    .ovf_now   (ovf_now),
    .match_now (match_now)
  );

  gpt_capture #(.W(W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .fclk_en  (fclk_en),
    .cap_in   (cap_in),
    .edge_sel (ctrl_q.edge_sel),
    .dual     (ctrl_q.cap_dual),
    .rearm    (ctrl_wr),
    .count    (count_o),
    .cap1     (cap1_o),
    .cap2     (cap2_o),
    .evt      (evt_cap)
  );

  gpt_pwm u_pwm (
    .clk       (clk),
    .rst       (rst),
    .load_def  (ctrl_wr),
    .new_def   (ctrl_new.def_lvl),
    .def_lvl   (ctrl_q.def_lvl),
    .trig      (ctrl_q.trig),
    .toggle    (ctrl_q.toggle),
    .ovf_now   (ovf_now),
    .match_now (match_now),
    .pwm       (pwm_o)
  );

  assign ctrl_o    = ctrl_q;
  assign gpo_cfg_o = ctrl_q.gpo;
endmodule

// File: rtl/gpt_timer_core_chk.sv
module gpt_timer_core_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         ctrl_wr,
  input logic         cnt_wr,
  input logic         trig_wr,
  input logic [15:0]  ctrl_o,
  input logic [W-1:0] count_o,
  input logic [W-1:0] load_q,
  input logic [W-1:0] match_q,
  input logic         evt_ovf,
  input logic         evt_match,
  input logic         evt_cap,
  input logic         pwm_o
);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_o[0] && !cnt_wr && !trig_wr) |=> $stable(count_o));

  p_ovf_stop_r4: assert property (@(posedge clk) disable iff (rst)
    evt_ovf |-> (ctrl_o[1] || !ctrl_o[0] || $past(ctrl_wr)));

  p_ovf_reload_r4: assert property (@(posedge clk) disable iff (rst)
    evt_ovf |-> (count_o == ($past(ctrl_o[1]) ? $past(load_q) : '0)));

  p_match_value_r7: assert property (@(posedge clk) disable iff (rst)
    evt_match |-> (count_o == $past(match_q)));

  p_no_capture_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_o[9:8] == 2'b00) |=> !evt_cap);

  p_pwm_idle_r10: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_o[11:10] == 2'b00) && !ctrl_wr) |=> (pwm_o == $past(ctrl_o[7])));
endmodule

bind gpt_timer_core gpt_timer_core_chk #(.W(W)) u_chk (.*);

// File: tb/gpt_timer_core_test.sv
module gpt_timer_core_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fclk_en = 1'b1;
  logic         ctrl_wr = 1'b0;
  logic [15:0]  ctrl_wdata = '0;
  logic         cnt_wr = 1'b0;
  logic [W-1:0] cnt_wdata = '0;
  logic         load_wr = 1'b0;
  logic [W-1:0] load_wdata = '0;
  logic         match_wr = 1'b0;
  logic [W-1:0] match_wdata = '0;
  logic         trig_wr = 1'b0;
  logic         cap_in = 1'b0;
  logic [W-1:0] count_o, cap1_o, cap2_o;
  logic [15:0]  ctrl_o;
  logic         evt_match, evt_ovf, evt_cap, pwm_o, gpo_cfg_o;

  int checks = 0;
  int errors = 0;

  localparam logic [15:0] RUN = 16'h0001, AR = 16'h0002, PRE = 16'h0020,
                          CE = 16'h0040, DEF = 16'h0080, TOG = 16'h1000,
                          DUAL = 16'h2000, GPO = 16'h4000;

  always #2 clk = ~clk;

  gpt_timer_core #(.W(W)) uut (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v; @(negedge clk); ctrl_wr = 1'b0;
  endtask
  task automatic wr_cnt(input logic [W-1:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; @(negedge clk); cnt_wr = 1'b0;
  endtask
  task automatic wr_load(input logic [W-1:0] v);
    load_wr = 1'b1; load_wdata = v; @(negedge clk); load_wr = 1'b0;
  endtask
  task automatic wr_match(input logic [W-1:0] v);
    match_wr = 1'b1; match_wdata = v; @(negedge clk); match_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", count_o, '0);
    chk("R1 ctrl", W'(ctrl_o), '0);
    chk("R1 cap1", cap1_o, '0);
    chk("R1 events", W'({evt_match, evt_ovf, evt_cap, pwm_o}), '0);
  endtask

  task automatic t_run();
    wr_cnt(32'd5); wr_ctrl(RUN);
    chk("R2 no step on start edge", count_o, 32'd5);
    step(4);
    chk("R2 four steps", count_o, 32'd9);
    fclk_en = 1'b0; step(3);
    chk("R2 hold without enable", count_o, 32'd9);
    fclk_en = 1'b1; step(1);
    chk("R2 resume", count_o, 32'd10);
    wr_ctrl(16'h0); step(2);
    chk("R2 hold when stopped", count_o, 32'd11);
  endtask

  task automatic t_prescale();
    wr_cnt(32'd0); wr_ctrl(RUN | PRE | 16'h0004);
    step(3);
    chk("R3 before 4th enable", count_o, 32'd0);
    step(1);
    chk("R3 first divided step", count_o, 32'd1);
    step(4);
    chk("R3 second divided step", count_o, 32'd2);
    wr_ctrl(16'h0);
  endtask

  task automatic t_ovf();
    wr_load(32'h100); wr_cnt(32'hFFFF_FFFE); wr_ctrl(RUN | AR);
    step(1);
    chk("R4 top", count_o, 32'hFFFF_FFFF);
    chk("R4 no early ovf", W'(evt_ovf), 0);
    step(1);
    chk("R4 reload value", count_o, 32'h100);
    chk("R4 ovf pulse", W'(evt_ovf), 1);
    chk("R4 still running", W'(ctrl_o[0]), 1);
    step(1);
    chk("R4 continue", count_o, 32'h101);
    chk("R4 pulse one cycle", W'(evt_ovf), 0);
    wr_ctrl(16'h0);
    wr_cnt(32'hFFFF_FFFF); wr_ctrl(RUN);
    step(1);
    chk("R4 wrap zero", count_o, 32'h0);
    chk("R4 ovf no reload", W'(evt_ovf), 1);
    chk("R4 run cleared", W'(ctrl_o[0]), 0);
    step(2);
    chk("R4 stopped", count_o, 32'h0);
  endtask

  task automatic t_trig();
    wr_load(32'h55);
    trig_wr = 1'b1; @(negedge clk); trig_wr = 1'b0;
    chk("R5 trigger reload", count_o, 32'h55);
    cnt_wr = 1'b1; cnt_wdata = 32'h77; trig_wr = 1'b1;
    @(negedge clk); cnt_wr = 1'b0; trig_wr = 1'b0;
    chk("R6 write beats trigger", count_o, 32'h77);
  endtask

  task automatic t_match();
    wr_match(32'd13); wr_cnt(32'd10); wr_ctrl(RUN | CE);
    step(2);
    chk("R7 no early match", W'(evt_match), 0);
    step(1);
    chk("R7 match count", count_o, 32'd13);
    chk("R7 match pulse", W'(evt_match), 1);
    step(1);
    chk("R7 pulse ends", W'(evt_match), 0);
    wr_ctrl(16'h0);
    wr_cnt(32'd10); wr_ctrl(RUN);
    step(3);
    chk("R7 disabled no event", W'(evt_match), 0);
    wr_ctrl(16'h0);
  endtask

  task automatic t_capture();
    wr_cnt(32'h40); wr_ctrl(16'h0100);
    cap_in = 1'b1; step(1);
    chk("R8 rising capture", cap1_o, 32'h40);
    chk("R8 capture event", W'(evt_cap), 1);
    step(1);
    chk("R8 event one cycle", W'(evt_cap), 0);
    wr_cnt(32'h50);
    cap_in = 1'b0; step(1);
    chk("R8 falling ignored", cap1_o, 32'h40);
    chk("R8 falling no event", W'(evt_cap), 0);
    wr_ctrl(16'h0300); wr_cnt(32'h51);
    cap_in = 1'b1; step(1);
    chk("R8 both rising", cap1_o, 32'h51);
    wr_cnt(32'h52);
    cap_in = 1'b0; step(1);
    chk("R8 both falling", cap1_o, 32'h52);
    chk("R8 both event", W'(evt_cap), 1);
    wr_ctrl(16'h0000); wr_cnt(32'h53);
    cap_in = 1'b1; step(1);
    chk("R8 none ignored", cap1_o, 32'h52);
    chk("R8 none no event", W'(evt_cap), 0);
    cap_in = 1'b0; step(1);
  endtask

  task automatic t_dual();
    wr_ctrl(DUAL | 16'h0300); wr_cnt(32'h60);
    cap_in = 1'b1; step(1);
    chk("R9 first to cap1", cap1_o, 32'h60);
    chk("R9 first no event", W'(evt_cap), 0);
    wr_cnt(32'h61);
    cap_in = 1'b0; step(1);
    chk("R9 second to cap2", cap2_o, 32'h61);
    chk("R9 second event", W'(evt_cap), 1);
    wr_ctrl(16'h0);
  endtask

  task automatic t_pwm();
    wr_load(32'h0); wr_match(32'hFFFF_FFFE); wr_cnt(32'hFFFF_FFFD);
    wr_ctrl(RUN | AR | CE | 16'h0800 | TOG);
    chk("R10 default level loaded", W'(pwm_o), 0);
    step(1);
    chk("R11 toggle on match", W'(pwm_o), 1);
    step(1);
    chk("R11 toggle holds", W'(pwm_o), 1);
    step(1);
    chk("R11 toggle on overflow", W'(pwm_o), 0);
    wr_ctrl(16'h0);
    wr_cnt(32'hFFFF_FFFE); wr_ctrl(RUN | AR | DEF | 16'h0400);
    chk("R10 default high", W'(pwm_o), 1);
    step(1);
    chk("R11 pulse idle", W'(pwm_o), 1);
    step(1);
    chk("R11 pulse active", W'(pwm_o), 0);
    step(1);
    chk("R11 pulse returns", W'(pwm_o), 1);
    wr_ctrl(DEF); step(2);
    chk("R10 none keeps default", W'(pwm_o), 1);
  endtask

  task automatic t_gpo();
    wr_ctrl(GPO | 16'h0300);
    chk("R12 ctrl readback", W'(ctrl_o), 32'h4300);
    chk("R12 gpo cfg", W'(gpo_cfg_o), 1);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    t_reset();
    t_run();
    t_prescale();
    t_ovf();
    t_trig();
    t_match();
    t_capture();
    t_dual();
    t_pwm();
    t_gpo();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule